// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo PCM serial stream into parallel samples. The stream arrives on three wires: a bit clock, a word clock and one data line. One word-clock period carries a left word and a right word, each sent MSB first in two's complement. Two configuration inputs select the framing convention and the word width at run time. Every received word is sign-extended to a 24-bit two's complement sample.

The bit-level work is done in the bit-clock domain. The framing conventions are I2S, left-justified, right-justified, and a DSP style that uses a one-bit frame-sync pulse. Once a complete left/right pair has been assembled, the pair crosses into the system clock domain through a toggle handshake. There it appears on two sample buses together with a single-cycle strobe.

The configuration is meant to change only while the block is held in reset. Bits in a slot that lie outside the selected word are ignored.

Top module: `serial_audio_rx`

## Requirements
- R1: With `cfg_fmt` = 0 (I2S), the MSB is the bit sampled one bit clock after the bit on which a word-clock change is first seen. A low word clock marks the left word and a high word clock marks the right word.
- R2: With `cfg_fmt` = 1 (left-justified), the MSB is the bit sampled on the same bit-clock edge that first sees the word-clock change. A high word clock marks left and a low word clock marks right.
- R3: With `cfg_fmt` = 2 (right-justified), the LSB is the last bit sampled before the word-clock change. The word is the last N bits before that change, and earlier bits in the slot have no effect. The channel polarity is the same as in R2.
- R4: With `cfg_fmt` = 3 (DSP), a word clock that is high for one bit marks frame start. The left MSB is the next bit, and the right MSB follows directly after the left LSB. The word clock is low for the rest of the frame.
- R5: `cfg_width` codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. Bits that follow the word within its slot have no effect on the sample.
- R6: Each sample output is the received word sign-extended from its selected width to 24 bits.
- R7: `pair_valid` pulses for exactly one system clock per stereo pair, after that pair's right word is captured. A right word with no left word captured before it produces no pulse.
- R8: `left_sample` and `right_sample` change only in a cycle where `pair_valid` is high, and hold their values otherwise.
- R9: While `rst_n` is low, `pair_valid` is low and both sample outputs are zero.
- R10: Serial data and word clock are sampled on the rising edge of the bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the sample outputs |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock, or the frame-sync pulse in DSP mode |
| sdata | input | 1 | Serial data, MSB first |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| cfg_width | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 bits |
| pair_valid | output | 1 | One-cycle strobe marking a new stereo pair |
| left_sample | output | 24 | Sign-extended left sample |
| right_sample | output | 24 | Sign-extended right sample |

## Verification
Slot bits outside the word carry random filler, so any off-by-one in MSB or LSB placement shows up as a wrong sample: a design that starts an I2S word on the word-clock edge, or ends a right-justified word one bit early, returns shifted values. Directed streams with the slot exactly as wide as the word check a right-justified capture on the boundary bit and a left-justified word that fills the slot. Full-scale negative and positive values at 16 and 24 bits check sign extension; a wrong extension bit flips the upper byte. Every stream starts from the idle word-clock level, so a design that strobes on an orphan right word produces an extra pair, and the per-stream pair count exposes it.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // word width in bits for a width code
  function automatic logic [CNT_W-1:0] width_of(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(18);
      2'd2:    return CNT_W'(20);
      default: return CNT_W'(24);
    endcase
  endfunction

  // sign-extend the low bits of a raw word according to the width code
  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] raw,
                                               input logic [1:0] code);
    case (code)
      2'd0:    return {{8{raw[15]}}, raw[15:0]};
      2'd1:    return {{6{raw[17]}}, raw[17:0]};
      2'd2:    return {{4{raw[19]}}, raw[19:0]};
      default: return raw;
    endcase
  endfunction
endpackage

// File: rtl/sarx_rst_sync.sv
module sarx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
(
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                wclk,
  input  logic                sdata,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_width,
  output logic [SAMPLE_W-1:0] pair_l,
  output logic [SAMPLE_W-1:0] pair_r,
  output logic                pair_tog
);
  // registered state
  logic [SAMPLE_W-1:0] shift_q, shift_d;
  logic                ws_q, ws_d;
  logic                ws_ok_q, ws_ok_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                active_q, active_d;
  logic                chan_r_q, chan_r_d;
  logic                pend_q, pend_d;
  logic                pend_r_q, pend_r_d;
  logic [SAMPLE_W-1:0] left_q, left_d;
  logic                have_l_q, have_l_d;
  logic [SAMPLE_W-1:0] pl_q, pl_d;
  logic [SAMPLE_W-1:0] pr_q, pr_d;
  logic                tog_q, tog_d;

  // decode
  fmt_e                fmt;
  logic [CNT_W-1:0]    wlen;
  logic [SAMPLE_W-1:0] word_now;
  logic                ws_chg;
  logic                fs_seen;
  logic                cap;
  logic                cap_right;
  logic [SAMPLE_W-1:0] cap_word;
  logic                start;
  logic                start_right;

  always_comb begin
    fmt      = fmt_e'(cfg_fmt);
    wlen     = width_of(cfg_width);
    word_now = {shift_q[SAMPLE_W-2:0], sdata};
    ws_chg   = ws_ok_q && (wclk != ws_q);
    fs_seen  = ws_ok_q && wclk && !ws_q;
  end

  // capture decision
  always_comb begin
    if (fmt == FMT_RJ) begin
      cap       = ws_chg;
      cap_right = !ws_q;
      cap_word  = shift_q;
    end else begin
      cap       = active_q && (CNT_W'(cnt_q + 1'b1) == wlen);
      cap_right = chan_r_q;
      cap_word  = word_now;
    end
  end

  // word start decision
  always_comb begin
    start       = 1'b0;
    start_right = 1'b0;
    pend_d      = 1'b0;
    pend_r_d    = pend_r_q;
    case (fmt)
      FMT_I2S: begin
        start       = pend_q;
        start_right = pend_r_q;
        if (ws_chg) begin
          pend_d   = 1'b1;
          pend_r_d = wclk;
        end
      end
      FMT_LJ: begin
        start       = ws_chg;
        start_right = !wclk;
      end
      FMT_DSP: begin
        start       = pend_q;
        start_right = pend_r_q;
        if (fs_seen) begin
          pend_d   = 1'b1;
          pend_r_d = 1'b0;
        end else if (cap && !chan_r_q) begin
          pend_d   = 1'b1;
          pend_r_d = 1'b1;
        end
      end
      default: begin
        start       = 1'b0;
        start_right = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    shift_d  = word_now;
    ws_d     = wclk;
    ws_ok_d  = 1'b1;
    cnt_d    = cnt_q;
    active_d = active_q;
    chan_r_d = chan_r_q;
    left_d   = left_q;
    have_l_d = have_l_q;
    pl_d     = pl_q;
    pr_d     = pr_q;
    tog_d    = tog_q;

    if (start) begin
      active_d = 1'b1;
      cnt_d    = CNT_W'(1);
      chan_r_d = start_right;
    end else if (cap && fmt != FMT_RJ) begin
      active_d = 1'b0;
    end else if (active_q) begin
      cnt_d = CNT_W'(cnt_q + 1'b1);
    end

    if (cap) begin
      if (!cap_right) begin
        left_d   = sext(cap_word, cfg_width);
        have_l_d = 1'b1;
      end else begin
        have_l_d = 1'b0;
        if (have_l_q) begin
          pl_d  = left_q;
          pr_d  = sext(cap_word, cfg_width);
          tog_d = !tog_q;
        end
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      ws_q     <= 1'b0;
      ws_ok_q  <= 1'b0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      chan_r_q <= 1'b0;
      pend_q   <= 1'b0;
      pend_r_q <= 1'b0;
      left_q   <= '0;
      have_l_q <= 1'b0;
      pl_q     <= '0;
      pr_q     <= '0;
      tog_q    <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      ws_q     <= ws_d;
      ws_ok_q  <= ws_ok_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      chan_r_q <= chan_r_d;
      pend_q   <= pend_d;
      pend_r_q <= pend_r_d;
      left_q   <= left_d;
      have_l_q <= have_l_d;
      pl_q     <= pl_d;
      pr_q     <= pr_d;
      tog_q    <= tog_d;
    end
  end

  assign pair_l   = pl_q;
  assign pair_r   = pr_q;
  assign pair_tog = tog_q;
endmodule

// File: rtl/sarx_pair_xfer.sv
module sarx_pair_xfer
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_tog,
  input  logic [SAMPLE_W-1:0] src_l,
  input  logic [SAMPLE_W-1:0] src_r,
  output logic                dst_valid,
  output logic [SAMPLE_W-1:0] dst_l,
  output logic [SAMPLE_W-1:0] dst_r
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   seen_q, seen_d;
  logic                   vld_q, vld_d;
  logic [SAMPLE_W-1:0]    l_q, l_d;
  logic [SAMPLE_W-1:0]    r_q, r_d;
  logic                   new_pair;

  always_comb begin
    sync_d   = {sync_q[SYNC_STAGES-2:0], src_tog};
    new_pair = sync_q[SYNC_STAGES-1] ^ seen_q;
    seen_d   = sync_q[SYNC_STAGES-1];
    vld_d    = new_pair;
    l_d      = l_q;
    r_d      = r_q;
    if (new_pair) begin
      l_d = src_l;
      r_d = src_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
    end else begin
      sync_q <= sync_d;
      seen_q <= seen_d;
      vld_q  <= vld_d;
      l_q    <= l_d;
      r_q    <= r_d;
    end
  end

  assign dst_valid = vld_q;
  assign dst_l     = l_q;
  assign dst_r     = r_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        wclk,
  input  logic        sdata,
  input  logic [1:0]  cfg_fmt,
  input  logic [1:0]  cfg_width,
  output logic        pair_valid,
  output logic [23:0] left_sample,
  output logic [23:0] right_sample
);
  import sarx_pkg::*;

  logic                rst_bit_n;
  logic                rst_sys_n;
  logic [SAMPLE_W-1:0] pl;
  logic [SAMPLE_W-1:0] pr;
  logic                ptog;

  sarx_rst_sync #(.STAGES(RST_STAGES)) u_rst_bit (
    .clk(bclk), .rst_n(rst_n), .rst_sync_n(rst_bit_n)
  );

  sarx_rst_sync #(.STAGES(RST_STAGES)) u_rst_sys (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sys_n)
  );

  sarx_deser u_deser (
    .bclk(bclk), .rst_n(rst_bit_n), .wclk(wclk), .sdata(sdata),
    .cfg_fmt(cfg_fmt), .cfg_width(cfg_width),
    .pair_l(pl), .pair_r(pr), .pair_tog(ptog)
  );

  sarx_pair_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk(clk), .rst_n(rst_sys_n), .src_tog(ptog), .src_l(pl), .src_r(pr),
    .dst_valid(pair_valid), .dst_l(left_sample), .dst_r(right_sample)
  );
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_width,
  input logic        pair_valid,
  input logic [23:0] left_sample,
  input logic [23:0] right_sample
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);  // R7

  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> $stable(left_sample));  // R8

  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> $stable(right_sample));  // R8

  AST_EXT_16: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && cfg_width == 2'd0) |->
      ((left_sample[23:15] == 9'h000 || left_sample[23:15] == 9'h1FF) &&
       (right_sample[23:15] == 9'h000 || right_sample[23:15] == 9'h1FF)));  // R6

  AST_EXT_20: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && cfg_width == 2'd2) |->
      ((left_sample[23:19] == 5'h00 || left_sample[23:19] == 5'h1F) &&
       (right_sample[23:19] == 5'h00 || right_sample[23:19] == 5'h1F)));  // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!pair_valid && left_sample == 24'h0 && right_sample == 24'h0));  // R9
endmodule

bind serial_audio_rx sarx_checker u_sarx_checker (
  .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .pair_valid(pair_valid),
  .left_sample(left_sample), .right_sample(right_sample)
);

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
  logic        clk;
  logic        rst_n;
  logic        bclk;
  logic        wclk;
  logic        sdata;
  logic [1:0]  cfg_fmt;
  logic [1:0]  cfg_width;
  logic        pair_valid;
  logic [23:0] left_sample;
  logic [23:0] right_sample;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [23:0] exp_l[$];
  logic [23:0] exp_r[$];
  int          n_recv   = 0;
  string       cur_tag  = "R1";

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
    .cfg_fmt(cfg_fmt), .cfg_width(cfg_width), .pair_valid(pair_valid),
    .left_sample(left_sample), .right_sample(right_sample)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    bclk = 1'b0;
    forever #35 bclk = ~bclk;
  end

  function automatic int wbits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] model_ext(input logic [31:0] v, input int w);
    logic signed [31:0] s;
    s = signed'(v);
    if (v[w-1]) s = s - (32'sd1 <<< w);
    return s[23:0];
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sampled away from the system clock's active edge
  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      n_recv++;
      if (exp_l.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R7 actual=extra pair expected=no pair");
      end else begin
        check({cur_tag, " R5 R6 left"}, left_sample, exp_l.pop_front());
        check({cur_tag, " R5 R6 right"}, right_sample, exp_r.pop_front());
      end
    end
  end

  task automatic put_bit(input logic ws, input logic d);
    @(negedge bclk);
    wclk  = ws;
    sdata = d;
  endtask

  function automatic logic idle_ws(input logic [1:0] f);
    return (f == 2'd0);
  endfunction

  task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
    rst_n     = 1'b0;
    cfg_fmt   = f;
    cfg_width = w;
    wclk      = idle_ws(f);
    sdata     = 1'b0;
    repeat (3) @(posedge bclk);
    @(negedge clk);
    // R9: quiet outputs under reset
    check("R9 valid", {23'h0, pair_valid}, 24'h0);
    check("R9 left", left_sample, 24'h0);
    check("R9 right", right_sample, 24'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) put_bit(idle_ws(f), 1'($urandom % 2));
  endtask

  // R10: all bits driven on the falling bit-clock edge, sampled on the rising one
  task automatic send_frame(input logic [1:0] f, input int w, input int slot,
                            input logic [31:0] lv, input logic [31:0] rv);
    exp_l.push_back(model_ext(lv, w));
    exp_r.push_back(model_ext(rv, w));
    if (f == 2'd3) begin
      for (int p = 0; p < 64; p++) begin
        logic d;
        d = 1'($urandom % 2);
        if (p >= 1 && p <= w) d = lv[w - p];
        else if (p > w && p <= 2 * w) d = rv[2 * w - p];
        put_bit(p == 0, d);
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [31:0] v;
        v = (ch == 0) ? lv : rv;
        for (int p = 0; p < slot; p++) begin
          logic d;
          logic ws;
          d  = 1'($urandom % 2);
          ws = (f == 2'd0) ? 1'(ch) : 1'(ch == 0);
          if (f == 2'd0 && p >= 1 && p <= w) d = v[w - p];
          if (f == 2'd1 && p < w) d = v[w - 1 - p];
          if (f == 2'd2 && p >= slot - w) d = v[slot - 1 - p];
          put_bit(ws, d);
        end
      end
    end
  endtask

  task automatic finish_stream(input logic [1:0] f);
    if (f == 2'd2) begin
      put_bit(1'b1, 1'($urandom % 2));
      put_bit(1'b1, 1'($urandom % 2));
    end
    repeat (120) @(negedge clk);
    n_checks++;
    if (exp_l.size() != 0) begin
      n_fail++;
      $display("FAIL R7 actual=%0d pairs missing expected=0", exp_l.size());
      exp_l.delete();
      exp_r.delete();
    end
  endtask

  task automatic run_stream(input logic [1:0] f, input logic [1:0] wc, input int slot,
                            input int frames, input logic [31:0] l0, input logic [31:0] r0,
                            input bit use_fixed);
    int w;
    logic [31:0] mask;
    w    = wbits(wc);
    mask = (32'h1 << w) - 1;
    cur_tag = fmt_tag(f);
    do_reset(f, wc);
    for (int k = 0; k < frames; k++) begin
      logic [31:0] lv;
      logic [31:0] rv;
      lv = use_fixed && k == 0 ? (l0 & mask) : ($urandom & mask);
      rv = use_fixed && k == 0 ? (r0 & mask) : ($urandom & mask);
      send_frame(f, w, slot, lv, rv);
    end
    finish_stream(f);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0;
    wclk = 1'b0;
    sdata = 1'b0;
    cfg_fmt = 2'd0;
    cfg_width = 2'd0;
    // directed corners: full-scale values (R6), exact-width slots (R2, R3)
    run_stream(2'd0, 2'd0, 32, 2, 32'h8000,   32'h7FFF,   1'b1);  // R1
    run_stream(2'd1, 2'd3, 24, 2, 32'h800000, 32'h7FFFFF, 1'b1);  // R2 slot==width
    run_stream(2'd2, 2'd1, 18, 2, 32'h20000,  32'h1FFFF,  1'b1);  // R3 slot==width
    run_stream(2'd2, 2'd0, 32, 2, 32'hFFFF,   32'h0001,   1'b1);  // R3 junk ahead of word
    run_stream(2'd3, 2'd3, 32, 2, 32'hFFFFFF, 32'h000000, 1'b1);  // R4 back-to-back words
    run_stream(2'd3, 2'd2, 32, 2, 32'h80000,  32'h7FFFF,  1'b1);  // R4 R6
    // constrained random mix of formats and widths
    for (int s = 0; s < 16; s++) begin
      logic [1:0] f;
      logic [1:0] wc;
      f  = 2'($urandom % 4);
      wc = 2'($urandom % 4);
      run_stream(f, wc, 32, 3, 32'h0, 32'h0, 1'b0);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule